// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Sequencer

This block carries out one access at a time to an external asynchronous static memory (SRAM, PSRAM or NOR flash). Four banks share the address lines, the data lines and the strobes, and each bank has its own active-low chip select. A request gives an address, write data, byte enables, a direction flag and a bank number. The block accepts it while idle. It then steps the external strobes through a fixed sequence of phases and ends the access with a one-cycle done pulse. For a read, the captured data is presented alongside that pulse.

The phase lengths are counted in clock cycles. Each bank has one timing table for reads and a separate one for writes, plus a byte-lane lead time, a multiplexed-bus flag and wait-input controls. The whole configuration of the addressed bank is captured when the request is accepted. A later change to the configuration inputs therefore has no effect on an access that is already running. The data pins are split into an output value, an output enable and an input value, so that the pad ring can form the bidirectional bus.

Top module: `xmem_async_seq`

## Requirements
- R1: While reset is held and immediately after it, every chip select, output enable, write enable, address-valid and byte-lane strobe is high, the data output enable is low, done is low and the request-ready output is high.
- R2: A request is accepted on a clock edge where both valid and ready are high. Ready then stays low until the access and its turnaround have finished. During the access exactly one chip select is low: bit b of the chip-select output, where b is the requested bank.
- R3: Each bank's timing table is 20 bits wide and occupies bits [20*b+19 : 20*b] of the table input. Within a table, bits [3:0] give address setup, [7:4] address hold, [11:8] data setup, [15:12] data hold and [19:16] turnaround. An access runs through byte-lane lead, address setup, address hold (multiplexed banks only), data setup and data hold, in that order. Each phase lasts its programmed number of cycles, and a value of 0 skips the phase. Data setup always lasts at least one cycle. Done is high for exactly one cycle, in the cycle that follows the last access cycle.
- R4: The byte-lane strobes carry the inverted byte enables during the lead phase and during every chip-select-low cycle. The 4-bit lead value of bank b sits at bits [4*b+3 : 4*b] of the lead input. The lead cycles all come before the chip select falls.
- R5: For a read, output enable is low exactly during data setup. The read data output equals the data input as sampled on the final data-setup cycle, and it is valid while done is high.
- R6: For a write, write enable is low exactly during data setup. The data output enable is high, carrying the write data, during data setup and data hold.
- R7: Address-valid is low exactly during address setup. On a bank with its multiplexing flag set, the data bus carries the low address bits during address setup and address hold.
- R8: Reads are timed by the read table and writes by the write table of the addressed bank.
- R9: Ready returns exactly "turnaround" cycles after the done cycle. The data output enable is low during reads, during turnaround and while idle.
- R10: If a bank's wait-enable bit is set, each clock edge in data setup at which the wait input equals the bank's wait-polarity bit (1 = active high, 0 = active low) holds data setup for one more cycle. If the wait-enable bit is clear, the wait input has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank number |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 16 | Captured read data |
| cfg_rd_tim | input | 80 | Read timing table for each bank |
| cfg_wr_tim | input | 80 | Write timing table for each bank |
| cfg_lead | input | 16 | Byte-lane lead cycles for each bank |
| cfg_mux | input | 4 | Multiplexed address/data bus, one bit per bank |
| cfg_wait_en | input | 4 | Wait input honoured, one bit per bank |
| cfg_wait_hi | input | 4 | Wait polarity, 1 = active high, one bit per bank |
| mem_ce_n | output | 4 | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_be_n | output | 2 | Byte-lane strobes, active low |
| mem_addr | output | 20 | Address bus |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | 16 | Data bus input value |
| mem_wait | input | 1 | Wait from the device |

## Verification
The assertions assume that the wait input is driven only to a defined level and that requests arrive on edges where their fields are stable. They do not assume that the configuration is held steady, because the block captures it at acceptance. The bench reprograms a bank only between accesses. It raises valid at a falling edge, after ready has been seen high. It moves the wait input only at falling edges, and its memory model answers with address-derived data only while output enable is low. The sweep covers zero and nonzero values of every phase and both directions, with the opposite table loaded with distinct values. It also covers wait pulses of several lengths at both polarities, and a wait input that is active but disabled.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    // width of every phase counter and timing field
    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LEAD = 3'd1,
        PH_ASET = 3'd2,
        PH_AHLD = 3'd3,
        PH_DSET = 3'd4,
        PH_DHLD = 3'd5,
        PH_TURN = 3'd6
    } phase_e;

    // one timing table; the first member occupies the most significant bits
    typedef struct packed {
        logic [CNT_W-1:0] turn;
        logic [CNT_W-1:0] dhold;
        logic [CNT_W-1:0] dsetup;
        logic [CNT_W-1:0] ahold;
        logic [CNT_W-1:0] asetup;
    } tim_t;

    localparam int TIM_W = $bits(tim_t);

    // everything needed to time a single access
    typedef struct packed {
        tim_t             tim;
        logic [CNT_W-1:0] lead;
        logic             mux;
        logic             wait_en;
        logic             wait_hi;
    } acc_cfg_t;

endpackage

// File: rtl/xmem_cfg_sel.sv
module xmem_cfg_sel
    import xmem_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic [NB*TIM_W-1:0]  rd_tim_i,
    input  logic [NB*TIM_W-1:0]  wr_tim_i,
    input  logic [NB*CNT_W-1:0]  lead_i,
    input  logic [NB-1:0]        mux_i,
    input  logic [NB-1:0]        wait_en_i,
    input  logic [NB-1:0]        wait_hi_i,
    input  logic [$clog2(NB)-1:0] bank_i,
    input  logic                 write_i,
    output acc_cfg_t             sel_o
);

    tim_t             rd_a   [NB];
    tim_t             wr_a   [NB];
    logic [CNT_W-1:0] lead_a [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign rd_a[b]   = rd_tim_i[b*TIM_W +: TIM_W];
        assign wr_a[b]   = wr_tim_i[b*TIM_W +: TIM_W];
        assign lead_a[b] = lead_i[b*CNT_W +: CNT_W];
    end

    always_comb begin
        sel_o.tim     = write_i ? wr_a[bank_i] : rd_a[bank_i];
        sel_o.lead    = lead_a[bank_i];
        sel_o.mux     = mux_i[bank_i];
        sel_o.wait_en = wait_en_i[bank_i];
        sel_o.wait_hi = wait_hi_i[bank_i];
    end

endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
    import xmem_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int BW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid_i,
    input  logic                  req_write_i,
    input  logic [$clog2(NB)-1:0] req_bank_i,
    input  logic [AW-1:0]         req_addr_i,
    input  logic [DW-1:0]         req_wdata_i,
    input  logic [BW-1:0]         req_be_i,
    input  acc_cfg_t              cfg_i,
    input  logic                  wait_i,
    input  logic [DW-1:0]         dq_i,
    output logic                  req_ready_o,
    output phase_e                phase_o,
    output logic                  write_o,
    output logic [$clog2(NB)-1:0] bank_o,
    output logic [AW-1:0]         addr_o,
    output logic [DW-1:0]         wdata_o,
    output logic [BW-1:0]         be_o,
    output logic                  mux_o,
    output logic                  done_o,
    output logic [DW-1:0]         rdata_o
);

    localparam int BKW = $clog2(NB);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             write;
        logic [BKW-1:0]   bank;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [BW-1:0]    be;
        acc_cfg_t         cfg;
        logic             done;
        logic [DW-1:0]    rdata;
    } st_t;

    st_t s_d, s_q;

    // phase that follows p; a zero length skips a phase (data setup never skipped)
    function automatic phase_e after_ph(input phase_e p, input acc_cfg_t c);
        logic   use_ah;
        phase_e n;
        use_ah = c.mux && (c.tim.ahold != '0);
        case (p)
            PH_IDLE: begin
                if (c.lead != '0)            n = PH_LEAD;
                else if (c.tim.asetup != '0) n = PH_ASET;
                else if (use_ah)             n = PH_AHLD;
                else                         n = PH_DSET;
            end
            PH_LEAD: begin
                if (c.tim.asetup != '0) n = PH_ASET;
                else if (use_ah)        n = PH_AHLD;
                else                    n = PH_DSET;
            end
            PH_ASET: n = use_ah ? PH_AHLD : PH_DSET;
            PH_AHLD: n = PH_DSET;
            PH_DSET: begin
                if (c.tim.dhold != '0)     n = PH_DHLD;
                else if (c.tim.turn != '0) n = PH_TURN;
                else                       n = PH_IDLE;
            end
            PH_DHLD: n = (c.tim.turn != '0) ? PH_TURN : PH_IDLE;
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

    // counter load value: phase length minus one
    function automatic logic [CNT_W-1:0] len_m1(input phase_e p, input acc_cfg_t c);
        logic [CNT_W-1:0] l;
        case (p)
            PH_LEAD: l = c.lead - 1'b1;
            PH_ASET: l = c.tim.asetup - 1'b1;
            PH_AHLD: l = c.tim.ahold - 1'b1;
            PH_DSET: l = (c.tim.dsetup == '0) ? '0 : c.tim.dsetup - 1'b1;
            PH_DHLD: l = c.tim.dhold - 1'b1;
            PH_TURN: l = c.tim.turn - 1'b1;
            default: l = '0;
        endcase
        return l;
    endfunction

    logic     idle;
    logic     wait_act;
    logic     adv;
    phase_e   nxt;
    acc_cfg_t cfg_use;

    assign idle     = (s_q.phase == PH_IDLE);
    assign wait_act = s_q.cfg.wait_en && (wait_i == s_q.cfg.wait_hi);
    assign cfg_use  = idle ? cfg_i : s_q.cfg;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        adv      = 1'b0;
        nxt      = s_q.phase;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    s_d.write = req_write_i;
                    s_d.bank  = req_bank_i;
                    s_d.addr  = req_addr_i;
                    s_d.wdata = req_wdata_i;
                    s_d.be    = req_be_i;
                    s_d.cfg   = cfg_i;
                    adv       = 1'b1;
                end
            end
            PH_DSET: begin
                if (!wait_act) begin
                    if (s_q.cnt == '0) begin
                        adv = 1'b1;
                        if (!s_q.write) s_d.rdata = dq_i;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            end
            default: begin
                if (s_q.cnt == '0) adv = 1'b1;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
        endcase
        if (adv) begin
            nxt       = after_ph(s_q.phase, cfg_use);
            s_d.phase = nxt;
            s_d.cnt   = len_m1(nxt, cfg_use);
            if ((s_q.phase == PH_DSET || s_q.phase == PH_DHLD) &&
                (nxt == PH_TURN || nxt == PH_IDLE))
                s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready_o = idle;
    assign phase_o     = s_q.phase;
    assign write_o     = s_q.write;
    assign bank_o      = s_q.bank;
    assign addr_o      = s_q.addr;
    assign wdata_o     = s_q.wdata;
    assign be_o        = s_q.be;
    assign mux_o       = s_q.cfg.mux;
    assign done_o      = s_q.done;
    assign rdata_o     = s_q.rdata;

    // R3: done lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: an accepted request makes the block busy
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o && req_valid_i) |=> !req_ready_o);

    // R10: an active wait level freezes data setup
    a_r10_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DSET && wait_act) |=> (s_q.phase == PH_DSET && $stable(s_q.cnt)));

    // R9: a nonzero turnaround keeps ready low in the done cycle
    a_r9_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && s_q.cfg.tim.turn != '0) |-> !req_ready_o);

endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
    import xmem_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int BW = 2
) (
    input  phase_e                phase_i,
    input  logic                  write_i,
    input  logic [$clog2(NB)-1:0] bank_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    input  logic [BW-1:0]         be_i,
    input  logic                  mux_i,
    output logic [NB-1:0]         ce_n_o,
    output logic                  oe_n_o,
    output logic                  we_n_o,
    output logic                  adv_n_o,
    output logic [BW-1:0]         be_n_o,
    output logic [AW-1:0]         addr_o,
    output logic [DW-1:0]         dq_o,
    output logic                  dq_oe_o
);

    logic in_addr;
    logic in_data;
    logic cs_on;

    assign in_addr = (phase_i == PH_ASET) || (phase_i == PH_AHLD);
    assign in_data = (phase_i == PH_DSET) || (phase_i == PH_DHLD);
    assign cs_on   = in_addr || in_data;

    always_comb begin
        ce_n_o = '1;
        if (cs_on) ce_n_o[bank_i] = 1'b0;
    end

    assign be_n_o  = (cs_on || phase_i == PH_LEAD) ? ~be_i : '1;
    assign adv_n_o = (phase_i != PH_ASET);
    assign oe_n_o  = !((phase_i == PH_DSET) && !write_i);
    assign we_n_o  = !((phase_i == PH_DSET) && write_i);
    assign addr_o  = addr_i;
    assign dq_o    = in_addr ? addr_i[DW-1:0] : wdata_i;
    assign dq_oe_o = (mux_i && in_addr) || (write_i && in_data);

endmodule

// File: rtl/xmem_async_seq.sv
module xmem_async_seq
    import xmem_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int BW = DW / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [$clog2(NB)-1:0] req_bank,
    input  logic [AW-1:0]         req_addr,
    input  logic [DW-1:0]         req_wdata,
    input  logic [BW-1:0]         req_be,
    output logic                  rsp_done,
    output logic [DW-1:0]         rsp_rdata,
    input  logic [NB*20-1:0]      cfg_rd_tim,
    input  logic [NB*20-1:0]      cfg_wr_tim,
    input  logic [NB*4-1:0]       cfg_lead,
    input  logic [NB-1:0]         cfg_mux,
    input  logic [NB-1:0]         cfg_wait_en,
    input  logic [NB-1:0]         cfg_wait_hi,
    output logic [NB-1:0]         mem_ce_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic                  mem_adv_n,
    output logic [BW-1:0]         mem_be_n,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DW-1:0]         mem_dq_i,
    input  logic                  mem_wait
);

    localparam int BKW = $clog2(NB);

    acc_cfg_t       sel_cfg;
    phase_e         phase;
    logic           a_write;
    logic [BKW-1:0] a_bank;
    logic [AW-1:0]  a_addr;
    logic [DW-1:0]  a_wdata;
    logic [BW-1:0]  a_be;
    logic           a_mux;

    xmem_cfg_sel #(.NB(NB)) u_sel (
        .rd_tim_i  (cfg_rd_tim),
        .wr_tim_i  (cfg_wr_tim),
        .lead_i    (cfg_lead),
        .mux_i     (cfg_mux),
        .wait_en_i (cfg_wait_en),
        .wait_hi_i (cfg_wait_hi),
        .bank_i    (req_bank),
        .write_i   (req_write),
        .sel_o     (sel_cfg)
    );

    xmem_phase_fsm #(.NB(NB), .AW(AW), .DW(DW), .BW(BW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_bank_i  (req_bank),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .req_be_i    (req_be),
        .cfg_i       (sel_cfg),
        .wait_i      (mem_wait),
        .dq_i        (mem_dq_i),
        .req_ready_o (req_ready),
        .phase_o     (phase),
        .write_o     (a_write),
        .bank_o      (a_bank),
        .addr_o      (a_addr),
        .wdata_o     (a_wdata),
        .be_o        (a_be),
        .mux_o       (a_mux),
        .done_o      (rsp_done),
        .rdata_o     (rsp_rdata)
    );

    xmem_pin_drv #(.NB(NB), .AW(AW), .DW(DW), .BW(BW)) u_pins (
        .phase_i (phase),
        .write_i (a_write),
        .bank_i  (a_bank),
        .addr_i  (a_addr),
        .wdata_i (a_wdata),
        .be_i    (a_be),
        .mux_i   (a_mux),
        .ce_n_o  (mem_ce_n),
        .oe_n_o  (mem_oe_n),
        .we_n_o  (mem_we_n),
        .adv_n_o (mem_adv_n),
        .be_n_o  (mem_be_n),
        .addr_o  (mem_addr),
        .dq_o    (mem_dq_o),
        .dq_oe_o (mem_dq_oe)
    );

    // R2: never more than one chip select low
    a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    // R5/R6: read and write strobes never overlap
    a_r5_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R9: the bus is released while the device drives it
    a_r9_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R1: idle and ready means no chip select
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n == '1));

endmodule

// File: tb/xmem_async_seq_test.sv
module xmem_async_seq_test;

    localparam int NB = 4;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int BW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n;
    logic           req_valid;
    logic           req_ready;
    logic           req_write;
    logic [1:0]     req_bank;
    logic [AW-1:0]  req_addr;
    logic [DW-1:0]  req_wdata;
    logic [BW-1:0]  req_be;
    logic           rsp_done;
    logic [DW-1:0]  rsp_rdata;
    logic [NB*20-1:0] cfg_rd_tim;
    logic [NB*20-1:0] cfg_wr_tim;
    logic [NB*4-1:0]  cfg_lead;
    logic [NB-1:0]  cfg_mux;
    logic [NB-1:0]  cfg_wait_en;
    logic [NB-1:0]  cfg_wait_hi;
    logic [NB-1:0]  mem_ce_n;
    logic           mem_oe_n;
    logic           mem_we_n;
    logic           mem_adv_n;
    logic [BW-1:0]  mem_be_n;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_dq_o;
    logic           mem_dq_oe;
    logic [DW-1:0]  mem_dq_i;
    logic           mem_wait;

    logic [19:0] b_rd   [NB];
    logic [19:0] b_wr   [NB];
    logic [3:0]  b_lead [NB];

    for (genvar b = 0; b < NB; b++) begin : g_cfg
        assign cfg_rd_tim[b*20 +: 20] = b_rd[b];
        assign cfg_wr_tim[b*20 +: 20] = b_wr[b];
        assign cfg_lead[b*4 +: 4]     = b_lead[b];
    end

    // device model: answers with address-derived data while output enable is low
    assign mem_dq_i = !mem_oe_n ? (mem_addr[15:0] ^ 16'h5A3C) : 16'hBEEF;

    xmem_async_seq uut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [19:0] mk(input int as_, input int ah_, input int ds_,
                                       input int dh_, input int tn_);
        return {4'(tn_), 4'(dh_), 4'(ds_), 4'(ah_), 4'(as_)};
    endfunction

    // one access; pulse_lvl is driven on the wait pin for k cycles of data setup
    task automatic xfer(input bit wr, input int b, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [BW-1:0] be,
                        input int k, input bit pulse_lvl, input bit counts);
        logic [19:0] tim;
        int as_, ah_, ds_, dh_, tn_, ld_, acc, extra, cyc, dcyc, rc;
        int ce_c, lead_c, oe_c, we_c, adv_c, oe_drv_c, bad_cs, bad_be, bad_dq, wl;
        bit seen;
        logic [DW-1:0] rd;
        tim  = wr ? b_wr[b] : b_rd[b];
        as_  = int'(tim[3:0]);   ah_ = int'(tim[7:4]);  ds_ = int'(tim[11:8]);
        dh_  = int'(tim[15:12]); tn_ = int'(tim[19:16]); ld_ = int'(b_lead[b]);
        if (!cfg_mux[b]) ah_ = 0;
        if (ds_ == 0) ds_ = 1;
        extra = counts ? k : 0;
        acc   = ld_ + as_ + ah_ + ds_ + extra + dh_;
        ce_c = 0; lead_c = 0; oe_c = 0; we_c = 0; adv_c = 0; oe_drv_c = 0;
        bad_cs = 0; bad_be = 0; bad_dq = 0; wl = k; seen = 0; dcyc = 0; rd = '0;
        mem_wait = !pulse_lvl;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr; req_bank = 2'(b); req_addr = a; req_wdata = wd; req_be = be;
        req_valid = 1'b1;
        cyc = 0;
        while (!seen && cyc < 80) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) req_valid = 1'b0;
            if (rsp_done) begin
                seen = 1; dcyc = cyc; rd = rsp_rdata;
                if (mem_ce_n !== 4'hF) bad_cs++;
            end else begin
                if (mem_ce_n !== 4'hF) begin
                    ce_c++;
                    if (mem_ce_n !== ~(4'b1 << b)) bad_cs++;
                    if (mem_be_n !== ~be) bad_be++;
                end else if (mem_be_n !== 2'b11) begin
                    lead_c++;
                    if (ce_c > 0 || mem_be_n !== ~be) bad_be++;
                end
                if (mem_dq_oe) oe_drv_c++;
                if (!mem_oe_n) oe_c++;
                if (!mem_we_n) begin
                    we_c++;
                    if (!mem_dq_oe || mem_dq_o !== wd) bad_dq++;
                end
                if (!mem_adv_n) begin
                    adv_c++;
                    if (cfg_mux[b] && (!mem_dq_oe || mem_dq_o !== a[15:0])) bad_dq++;
                end
                if ((!mem_oe_n || !mem_we_n) && wl > 0) begin
                    mem_wait = pulse_lvl; wl--;
                end else begin
                    mem_wait = !pulse_lvl;
                end
            end
        end
        chk("R3 done cycle", 32'(dcyc), 32'(acc + 1));
        chk("R2 single chip select of bank", 32'(bad_cs), 0);
        chk("R3 chip select cycles", 32'(ce_c), 32'(acc - ld_));
        chk("R4 lead cycles", 32'(lead_c), 32'(ld_));
        chk("R4 byte lane value/order", 32'(bad_be), 0);
        chk("R7 address valid cycles", 32'(adv_c), 32'(as_));
        chk("R5 output enable cycles", 32'(oe_c), wr ? 0 : 32'(ds_ + extra));
        chk("R6 write enable cycles", 32'(we_c), wr ? 32'(ds_ + extra) : 0);
        chk("R6/R7 bus content", 32'(bad_dq), 0);
        chk("R8/R9 bus drive cycles", 32'(oe_drv_c),
            32'((cfg_mux[b] ? as_ + ah_ : 0) + (wr ? ds_ + extra + dh_ : 0)));
        if (!wr) chk("R5 read data", 32'(rd), 32'(a[15:0] ^ 16'h5A3C));
        rc = dcyc;
        while (!req_ready && rc < dcyc + 40) begin
            @(negedge clk);
            rc++;
            if (mem_dq_oe || mem_ce_n !== 4'hF) bad_dq++;
        end
        chk("R9 turnaround length", 32'(rc - dcyc), 32'(tn_));
        chk("R9 quiet during turnaround", 32'(bad_dq), 0);
        @(negedge clk);
        chk("R3 done single pulse", 32'(rsp_done), 0);
        chk("R9 idle release", {30'd0, mem_dq_oe, mem_ce_n == 4'hF}, 32'd1);
        mem_wait = !pulse_lvl;
    endtask

    int asv[3] = '{0, 1, 3};
    int dsv[3] = '{0, 1, 2};

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int idx;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = '0;
        req_addr = '0; req_wdata = '0; req_be = '0; mem_wait = 1'b1;
        cfg_mux = '0; cfg_wait_en = '0; cfg_wait_hi = '0;
        for (int b = 0; b < NB; b++) begin
            b_rd[b] = mk(1, 0, 1, 0, 0); b_wr[b] = mk(1, 0, 1, 0, 0); b_lead[b] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 chip selects", 32'(mem_ce_n), 32'hF);
        chk("R1 strobes", {29'd0, mem_oe_n, mem_we_n, mem_adv_n}, 32'h7);
        chk("R1 byte lanes", 32'(mem_be_n), 32'h3);
        chk("R1 bus released", 32'(mem_dq_oe), 0);
        chk("R1 done low", 32'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 1);

        // sweep of phase lengths, direction, lead and multiplexing (R2-R9)
        idx = 0;
        for (int ia = 0; ia < 3; ia++)
        for (int id = 0; id < 3; id++)
        for (int dh = 0; dh <= 2; dh += 2)
        for (int tn = 0; tn <= 2; tn += 2)
        for (int ah = 0; ah <= 1; ah++)
        for (int mx = 0; mx <= 1; mx++)
        for (int ld = 0; ld <= 2; ld += 2)
        for (int wr = 0; wr <= 1; wr++) begin
            int b;
            b = idx % NB;
            if (wr != 0) begin
                b_wr[b] = mk(asv[ia], ah, dsv[id], dh, tn); b_rd[b] = mk(4, 4, 4, 4, 4);
            end else begin
                b_rd[b] = mk(asv[ia], ah, dsv[id], dh, tn); b_wr[b] = mk(4, 4, 4, 4, 4);
            end
            b_lead[b] = 4'(ld);
            cfg_mux[b] = mx[0];
            cfg_wait_en[b] = 1'b0;
            cfg_wait_hi[b] = 1'b0;
            // wait held at its active-low level while disabled: R10 no effect
            xfer(wr[0], b, 20'(32'h1357 * (idx + 1)), 16'(32'hA5C3 + idx * 7),
                 2'((idx % 3) + 1), 3, 1'b0, 1'b0);
            idx++;
        end

        // R10 wait, both polarities, reads and writes
        for (int pol = 0; pol <= 1; pol++)
        for (int k = 0; k <= 4; k++)
        for (int wr = 0; wr <= 1; wr++) begin
            b_rd[1] = mk(1, 0, 2, 1, 1);
            b_wr[1] = mk(2, 0, 1, 1, 1);
            b_lead[1] = 4'd1;
            cfg_mux[1] = 1'b0;
            cfg_wait_en[1] = 1'b1;
            cfg_wait_hi[1] = pol[0];
            xfer(wr[0], 1, 20'(32'h0F0F0 + k), 16'(32'h1234 + k), 2'b11, k, pol[0], 1'b1);
        end
        // R10 disabled with active-high polarity: pulses ignored
        cfg_wait_en[1] = 1'b0;
        cfg_wait_hi[1] = 1'b1;
        xfer(1'b0, 1, 20'h0ABCD, 16'h0, 2'b01, 4, 1'b1, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule